// File: doc/BRIEF.md
# Single-Wire Return-to-Zero Frame Transmitter

This block is the controller-side encoder for a chain of display drivers that share one data wire. A host writes 32-bit words into a small buffer through a valid/ready port. A start pulse then launches a frame of `NUM_PKT` packets on `line_out`. Every bit takes one fixed-length cell that opens with a high pulse. A short pulse means 0 and a long pulse means 1, and the rest of the cell is low. Each packet goes out least significant bit first. The first word taken from the buffer is consumed by the device nearest the transmitter, the next word by the device after it, and so on down the chain.

After the last cell the line is held low for a long latch period so that every device in the chain takes its new data at the same moment. Then `done` pulses for one clock. The wire must never sit low for longer than the receivers tolerate in the middle of a frame. So if the buffer has no word ready within a stall budget, the transmitter gives up on the frame. It raises `underrun` and goes straight to the latch period. All timing is derived from the clock frequency parameter, rounded to the nearest clock.

Top module: `rz_frame_tx`

## Requirements
- R1: After reset `line_out`, `busy`, `done` and `underrun` are 0 and `in_ready` is 1. While `busy` is 0 the line stays low.
- R2: A 0 bit is a high pulse of round(ZERO_HI_NS·f) clocks (20 at defaults) and a 1 bit is a high pulse of round(ONE_HI_NS·f) clocks (40 at defaults). The rest of the cell is low.
- R3: Within a packet the bits go out least significant bit (bit 0) first and most significant bit (bit 31) last.
- R4: A frame carries exactly `NUM_PKT` packets, taken from the buffer in the order the words were accepted. The first accepted word is sent first.
- R5: When words are already buffered, consecutive rising edges on the line are exactly one cell apart, round(CELL_NS·f) clocks (63 at defaults). This holds within a packet and across packet boundaries.
- R6: After the last cell of a frame the line stays low for at least round(LATCH_NS·f) clocks (10000 at defaults) before `done` is raised. `done` lasts one clock and `busy` falls in the same cycle.
- R7: If no word is available for round(STALL_NS·f) clocks (2000 at defaults) while a packet is awaited, `underrun` is set and the frame moves straight to the latch period without sending further pulses. `underrun` stays set until the next accepted start, which clears it.
- R8: A start pulse while `busy` is 1 is ignored. No second frame follows the current one.
- R9: `in_ready` is 0 when `BUF_DEPTH` words are held. A word offered with `in_valid` while `in_ready` is 0 is dropped and never transmitted.
- R10: A start with an empty buffer sends no pulse, ends with `underrun` set and pulses `done` after the stall and latch periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a frame when idle |
| in_data | input | WORD_W | Packet word offered to the buffer |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Buffer can accept a word |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at the end of the latch period |
| underrun | output | 1 | The last frame was cut short for lack of data |
| line_out | output | 1 | Single-wire return-to-zero data line |

## Verification
The main encoding path is driven with four kinds of packets. Mixed words such as 0xA5C30F81 and 0x12345678 reveal bit-order or word-order swaps. An all-zero packet and an all-one packet show whether each pulse width is produced on its own for a whole packet. Every pulse is decoded at the line and its width, cell spacing and position are compared with the words that were pushed. Buffer occupancy is varied as well. A full buffer tests the drop of an extra word. A partly filled buffer exposes a stall and the underrun path. An empty buffer tests the case where no pulse may appear.

// File: rtl/rz_pkg.sv
package rz_pkg;

  // Convert a duration in ns to clock cycles, rounded to nearest.
  function automatic int ns2cyc(input longint hz, input longint ns);
    longint prod;
    prod = hz * ns;
    return int'((prod + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_SEND  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_LATCH = 3'd4
  } tx_state_e;

endpackage

// File: rtl/rz_word_fifo.sv
module rz_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr[AW-1:0]];

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rz_cell_gen.sv
module rz_cell_gen #(
  parameter int CELL_CYC = 63,
  parameter int T0_CYC   = 20,
  parameter int T1_CYC   = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic bit_val,
  output logic active,
  output logic last_cyc,
  output logic line
);
  localparam int CW = $clog2(CELL_CYC + 1);
  localparam logic [CW-1:0] CELL_END = CW'(CELL_CYC - 1);
  localparam logic [CW-1:0] HI0      = CW'(T0_CYC);
  localparam logic [CW-1:0] HI1      = CW'(T1_CYC);

  logic [CW-1:0] cnt, hi_len;
  logic [CW-1:0] cnt_nxt;

  assign last_cyc = active && (cnt == CELL_END);
  assign cnt_nxt  = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      hi_len <= '0;
      line   <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      hi_len <= bit_val ? HI1 : HI0;
      line   <= 1'b1;
    end else if (active) begin
      if (cnt == CELL_END) begin
        active <= 1'b0;
        line   <= 1'b0;
      end else begin
        cnt  <= cnt_nxt;
        line <= (cnt_nxt < hi_len);
      end
    end else begin
      line <= 1'b0;
    end
  end
endmodule

// File: rtl/rz_frame_ctrl.sv
module rz_frame_ctrl
  import rz_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUM_PKT   = 4,
  parameter int STALL_CYC = 2000,
  parameter int LATCH_CYC = 10000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_pop,
  input  logic         cell_active,
  input  logic         cell_last,
  output logic         cell_load,
  output logic         cell_bit,
  output logic         busy,
  output logic         done,
  output logic         underrun
);
  localparam int BW = $clog2(W);
  localparam int PW = (NUM_PKT > 1) ? $clog2(NUM_PKT) : 1;
  localparam int SW = $clog2(STALL_CYC + 1);
  localparam int LW = $clog2(LATCH_CYC + 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(W - 1);
  localparam logic [PW-1:0] PKT_LAST   = PW'(NUM_PKT - 1);
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_CYC - 1);
  localparam logic [LW-1:0] LATCH_LAST = LW'(LATCH_CYC - 1);

  tx_state_e     state;
  logic [W-1:0]  shreg;
  logic [BW-1:0] bit_idx;
  logic [PW-1:0] pkt_idx;
  logic [SW-1:0] stall_cnt;
  logic [LW-1:0] latch_cnt;
  logic          can_load;

  always_comb begin
    can_load  = !cell_active || cell_last;
    cell_load = (state == ST_SEND) && can_load;
    cell_bit  = shreg[0];
    fifo_pop  = (state == ST_FETCH) && !fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_idx   <= '0;
      pkt_idx   <= '0;
      stall_cnt <= '0;
      latch_cnt <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_FETCH;
            busy      <= 1'b1;
            underrun  <= 1'b0;
            pkt_idx   <= '0;
            stall_cnt <= '0;
          end
        end
        ST_FETCH: begin
          if (!fifo_empty) begin
            shreg     <= fifo_data;
            bit_idx   <= '0;
            stall_cnt <= '0;
            state     <= ST_SEND;
          end else if (stall_cnt == STALL_LAST) begin
            underrun <= 1'b1;
            state    <= ST_DRAIN;
          end else begin
            stall_cnt <= stall_cnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (can_load) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == BIT_LAST) begin
              if (pkt_idx == PKT_LAST) begin
                state <= ST_DRAIN;
              end else begin
                pkt_idx <= pkt_idx + 1'b1;
                state   <= ST_FETCH;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (!cell_active) begin
            latch_cnt <= '0;
            state     <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (latch_cnt == LATCH_LAST) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            latch_cnt <= latch_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rz_frame_tx.sv
module rz_frame_tx #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WORD_W     = 32,
  parameter int NUM_PKT    = 4,
  parameter int BUF_DEPTH  = 4,
  parameter int CELL_NS    = 1250,
  parameter int ZERO_HI_NS = 400,
  parameter int ONE_HI_NS  = 800,
  parameter int LATCH_NS   = 200_000,
  parameter int STALL_NS   = 40_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              underrun,
  output logic              line_out
);
  localparam int CELL_CYC  = rz_pkg::ns2cyc(CLK_HZ, CELL_NS);
  localparam int T0_CYC    = rz_pkg::ns2cyc(CLK_HZ, ZERO_HI_NS);
  localparam int T1_CYC    = rz_pkg::ns2cyc(CLK_HZ, ONE_HI_NS);
  localparam int LATCH_CYC = rz_pkg::ns2cyc(CLK_HZ, LATCH_NS);
  localparam int STALL_CYC = rz_pkg::ns2cyc(CLK_HZ, STALL_NS);

  logic [WORD_W-1:0] fifo_data;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic              cell_active, cell_last, cell_load, cell_bit;

  assign in_ready = !fifo_full;

  rz_word_fifo #(
    .W     (WORD_W),
    .DEPTH (BUF_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (in_valid),
    .wdata (in_data),
    .pop   (fifo_pop),
    .rdata (fifo_data),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  rz_frame_ctrl #(
    .W         (WORD_W),
    .NUM_PKT   (NUM_PKT),
    .STALL_CYC (STALL_CYC),
    .LATCH_CYC (LATCH_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .fifo_empty  (fifo_empty),
    .fifo_data   (fifo_data),
    .fifo_pop    (fifo_pop),
    .cell_active (cell_active),
    .cell_last   (cell_last),
    .cell_load   (cell_load),
    .cell_bit    (cell_bit),
    .busy        (busy),
    .done        (done),
    .underrun    (underrun)
  );

  rz_cell_gen #(
    .CELL_CYC (CELL_CYC),
    .T0_CYC   (T0_CYC),
    .T1_CYC   (T1_CYC)
  ) u_cell (
    .clk      (clk),
    .rst      (rst),
    .load     (cell_load),
    .bit_val  (cell_bit),
    .active   (cell_active),
    .last_cyc (cell_last),
    .line     (line_out)
  );
endmodule

// File: rtl/rz_frame_tx_chk.sv
module rz_frame_tx_chk #(
  parameter int T1_CYC    = 40,
  parameter int LATCH_CYC = 10000
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic underrun,
  input logic line_out
);
  int unsigned hi_run, lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= line_out ? hi_run + 1 : 0;
      lo_run <= line_out ? 0 : lo_run + 1;
    end
  end

  // R1: the line is low outside a frame
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

  // R2: no high pulse outlasts the long-pulse width
  a_r2_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    line_out |-> (hi_run < T1_CYC));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: busy only ends together with done
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6: the latch low period precedes done
  a_r6_latch_low: assert property (@(posedge clk) disable iff (rst)
    done |-> (lo_run >= LATCH_CYC));

  // R7: underrun is only raised inside a frame
  a_r7_underrun_in_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> busy);

  // R8: a frame only begins from a start request
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind rz_frame_tx rz_frame_tx_chk #(
  .T1_CYC    (T1_CYC),
  .LATCH_CYC (LATCH_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .underrun (underrun),
  .line_out (line_out)
);

// File: tb/rz_frame_tx_bench.sv
module rz_frame_tx_bench;
  localparam int NPKT = 2;
  localparam int DEP  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, busy, done, underrun, line_out;

  always #10 clk = ~clk;

  rz_frame_tx #(.NUM_PKT(NPKT), .BUF_DEPTH(DEP)) u_rz_frame_tx (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .busy(busy), .done(done), .underrun(underrun),
    .line_out(line_out)
  );

  int total = 0, fails = 0, cyc = 0;

  // line decoder
  logic        prev_ln = 1'b0;
  int          hi_cnt = 0, since_rise = 0, have_rise = 0;
  int          min_per, max_per, bad_w, nbits, rx_cnt, low_run = 0;
  int          done_cnt = 0, low_at_done = 0;
  logic [31:0] cur;
  logic [31:0] rx_words [16];

  task automatic clear_mon();
    min_per = 1 << 30; max_per = 0; bad_w = 0; nbits = 0; rx_cnt = 0;
    have_rise = 0; cur = '0;
  endtask

  initial clear_mon();

  always @(negedge clk) begin
    if (line_out && !prev_ln) begin
      if (have_rise != 0) begin
        if (since_rise < min_per) min_per = since_rise;
        if (since_rise > max_per) max_per = since_rise;
      end
      since_rise = 1; have_rise = 1; hi_cnt = 1;
    end else begin
      since_rise++;
      if (line_out) hi_cnt++;
    end
    if (!line_out && prev_ln) begin
      if (hi_cnt != 20 && hi_cnt != 40) bad_w++;
      cur[nbits % 32] = (hi_cnt >= 30);
      nbits++;
      if (nbits % 32 == 0 && rx_cnt < 16) begin
        rx_words[rx_cnt] = cur;
        rx_cnt++;
      end
    end
    low_run = line_out ? 0 : low_run + 1;
    if (done) begin done_cnt++; low_at_done = low_run; end
    prev_ln = line_out;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      total++; fails++;
      $display("FAIL watchdog (all): actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); in_data = w; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic start_frame();
    @(posedge clk); #1 clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int d0 = done_cnt;
    for (int n = 0; n < 40000 && done_cnt == d0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(line_out == 0, "R1 line", line_out, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(underrun == 0, "R1 underrun", underrun, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_basic();
    int d0;
    push(32'hA5C3_0F81); push(32'h1234_5678);
    d0 = done_cnt;
    start_frame();
    wait_done();
    chk(rx_cnt == 2, "R4 packet count", rx_cnt, 2);
    chk(rx_words[0] == 32'hA5C3_0F81, "R3 R4 first word", rx_words[0], 32'hA5C3_0F81);
    chk(rx_words[1] == 32'h1234_5678, "R3 R4 second word", rx_words[1], 32'h1234_5678);
    chk(bad_w == 0, "R2 pulse widths", bad_w, 0);
    chk(min_per == 63 && max_per == 63, "R5 cell spacing", max_per, 63);
    chk(low_at_done >= 10000, "R6 latch low", low_at_done, 10000);
    chk(done_cnt == d0 + 1, "R6 single done", done_cnt - d0, 1);
    chk(busy == 0 && underrun == 0, "R6 busy cleared", {busy, underrun}, 0);
    chk(line_out == 0, "R1 idle after frame", line_out, 0);
  endtask

  task automatic t_patterns();
    push(32'h0000_0000); push(32'hFFFF_FFFF);
    start_frame();
    wait_done();
    chk(rx_cnt == 2 && rx_words[0] == 32'h0, "R2 all-zero packet", rx_words[0], 0);
    chk(rx_words[1] == 32'hFFFF_FFFF, "R2 all-one packet", rx_words[1], 32'hFFFF_FFFF);
    chk(bad_w == 0, "R2 widths uniform", bad_w, 0);
    chk(min_per == 63 && max_per == 63, "R5 spacing on uniform data", min_per, 63);
  endtask

  task automatic t_start_ignored();
    int d0;
    push(32'hDEAD_BEEF); push(32'h0BAD_F00D);
    d0 = done_cnt;
    start_frame();
    repeat (100) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (200) @(negedge clk);
    chk(busy == 0, "R8 no second frame", busy, 0);
    chk(done_cnt == d0 + 1, "R8 one done", done_cnt - d0, 1);
    chk(rx_cnt == 2 && rx_words[1] == 32'h0BAD_F00D, "R8 frame intact", rx_cnt, 2);
  endtask

  task automatic t_full();
    push(32'h1111_1111); push(32'h2222_2222); push(32'h3333_3333); push(32'h4444_4444);
    @(negedge clk);
    chk(in_ready == 0, "R9 ready low when full", in_ready, 0);
    in_data = 32'h5555_5555; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 0, "R9 still full", in_ready, 0);
    start_frame(); wait_done();
    chk(rx_words[0] == 32'h1111_1111 && rx_words[1] == 32'h2222_2222,
        "R4 full buffer order", rx_words[1], 32'h2222_2222);
    start_frame(); wait_done();
    chk(rx_cnt == 2 && rx_words[0] == 32'h3333_3333 && rx_words[1] == 32'h4444_4444,
        "R9 dropped word absent", rx_words[1], 32'h4444_4444);
    chk(underrun == 0, "R9 no underrun", underrun, 0);
    start_frame(); wait_done();
    chk(nbits == 0, "R10 no pulses when empty", nbits, 0);
    chk(underrun == 1, "R10 underrun on empty", underrun, 1);
    chk(low_at_done >= 12000, "R10 stall plus latch", low_at_done, 12000);
  endtask

  task automatic t_underrun();
    push(32'hC0DE_0042);
    start_frame(); wait_done();
    chk(rx_cnt == 1 && rx_words[0] == 32'hC0DE_0042, "R7 partial frame", rx_cnt, 1);
    chk(nbits == 32, "R7 no pulses after stall", nbits, 32);
    chk(underrun == 1, "R7 underrun set", underrun, 1);
    chk(low_at_done >= 10000 && low_at_done < 12100, "R7 stall then latch", low_at_done, 12000);
    push(32'h0F0F_0F0F); push(32'hF0F0_F0F0);
    start_frame();
    @(negedge clk);
    chk(underrun == 0 && busy == 1, "R7 cleared on start", underrun, 0);
    wait_done();
    chk(underrun == 0 && rx_cnt == 2 && rx_words[1] == 32'hF0F0_F0F0, "R7 recovery frame",
        rx_words[1], 32'hF0F0_F0F0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_patterns();
    t_start_ignored();
    t_full();
    t_underrun();
    summary();
    $finish;
  end
endmodule